// File: doc/BRIEF.md
# Multiprocessor Interrupt Mask Controller

This block gathers level-sensitive device interrupt lines for a system of up to four processors. A single global mask filters them. Software changes that mask only through two write ports: one port sets bits and the other clears them. A steering register names the one processor that receives every unmasked shared device request. Each processor also has a private register of software interrupt levels. Any processor can raise or drop a level in another processor's register, which gives interprocessor signalling.

Every source bit belongs to a fixed priority level from 2 to 13. Each processor also has a private tick line that requests level 14. For each processor the block encodes the highest active level into a registered 4-bit output. The value 0 means that nothing is requested. A small word-addressed register port with a single write strobe and a combinational read gives software its access.

Top module: `irq_mask_ctrl`

## Requirements
- R1: While reset is low, all mask bits are forced to one, every software pending bit is cleared, the steering register is set to processor 0 and every level output is 0.
- R2: A write to the mask-set port (address 1) sets each mask bit whose data bit is one and leaves the other bits unchanged. A read of address 0 returns the current mask.
- R3: A write to the mask-clear port (address 2) clears each mask bit whose data bit is one and leaves the other bits unchanged. Addresses 1 and 2 read as 0.
- R4: While mask bit 31 is one, no device source and no tick reaches any processor. Software levels are still delivered.
- R5: Device bits map to levels as follows. Bits 0 and 7 give level 2. Bits 1 and 8 give level 3. Bit 18 gives level 4. Bits 2 and 9 give level 5. Bit 16 gives level 6. Bits 3 and 10 give level 7. Bit 20 gives level 8. Bits 4, 11 and 30 give level 9. Bit 19 gives level 10. Bits 5, 12 and 22 give level 11. Bits 14 and 15 give level 12. Bit 17 gives level 13. A device bit is effective only while its own mask bit is zero.
- R6: Processor c's tick line requests level 14 while mask bit 7 is zero. Bits 6, 13, 21, 28, 29 and 31 drive no level.
- R7: Shared device levels reach only the processor named in the steering register (address 3, index in the low bits). The tick lines ignore the steering register.
- R8: A write to the steering register whose whole data word is not below the processor count leaves the register unchanged.
- R9: Processor c's port group starts at address 16+4c. Offset 1 sets and offset 2 clears software level n, which is data bit 16+n for n from 1 to 15. Data bits 16 and below are ignored, and the other processors are unaffected.
- R10: Reading offset 0 of processor c returns its software levels in bits 31:17. Bits 15:1 hold its per-level device requests before masking, with shared sources counted only when c is the target and tick at level 14. Bits 16 and 0 read as 0. Offset 3 reads as 0.
- R11: Each level output is the highest active level among the processor's software levels, its steered effective device levels and its tick. The value 0 means none. A change on an input line appears one clock edge later, and a register write appears two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| dev_irq | input | 32 | Level-sensitive device source lines |
| tick_irq | input | NCPU | Per-processor tick lines (level 14) |
| cpu_lvl | output | 4*NCPU | Level for processor c in bits 4c+3:4c |

## Verification
A level output responds to a source or tick line one edge after the line changes, because only the output register lies in that path. It responds to a mask, steering or software write two edges after the write is presented: the write lands in its register on the first edge and the output register picks it up on the second. The bench drives on falling edges. After an input change it waits one full cycle before it samples a level. After a write it waits one further cycle. Register reads are combinational, so they are sampled a moment after the address is applied, between edges.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
   localparam int unsigned WORD_W       = 32;
   localparam int unsigned ADDR_W       = 5;
   localparam int unsigned NLVL         = 16;
   localparam int unsigned LVL_W        = 4;
   localparam int unsigned SOFT_LSB     = 16;
   localparam int unsigned MASK_ALL_BIT = 31;
   localparam int unsigned TICK_GATE    = 7;
   localparam int unsigned TICK_LVL     = 14;
   localparam int unsigned CPU_BASE     = 16;

   typedef logic [NLVL-1:0]   lvl_vec_t;
   typedef logic [WORD_W-1:0] word_t;

   typedef enum logic [1:0] {
      OP_READ = 2'd0,
      OP_SET  = 2'd1,
      OP_CLR  = 2'd2,
      OP_AUX  = 2'd3
   } port_op_e;

   // source bits feeding each priority level (level 14 comes from tick lines)
   localparam word_t LVL_SRC [NLVL] = '{
      32'h0000_0000, 32'h0000_0000, 32'h0000_0081, 32'h0000_0102,
      32'h0004_0000, 32'h0000_0204, 32'h0001_0000, 32'h0000_0408,
      32'h0010_0000, 32'h4000_0810, 32'h0008_0000, 32'h0040_1020,
      32'h0000_C000, 32'h0002_0000, 32'h0000_0000, 32'h0000_0000
   };

   function automatic logic [LVL_W-1:0] top_level(input lvl_vec_t v);
      logic [LVL_W-1:0] r;
      r = '0;
      for (int i = 1; i < NLVL; i++)
         if (v[i]) r = LVL_W'(i);
      return r;
   endfunction
endpackage

// File: rtl/irq_level_map.sv
module irq_level_map
   import irq_mask_pkg::*;
(
   input  word_t    src,
   output lvl_vec_t lv
);
   for (genvar l = 0; l < NLVL; l++) begin : g_lvl
      assign lv[l] = |(src & LVL_SRC[l]);
   end
endmodule

// File: rtl/irq_global_regs.sv
module irq_global_regs
   import irq_mask_pkg::*;
#(
   parameter int NCPU  = 4,
   parameter int CPU_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  word_t            wdata,
   output word_t            mask_q,
   output logic [CPU_W-1:0] tgt_q
);
   logic     glob_sel;
   port_op_e op;

   assign glob_sel = wr_en && (addr < ADDR_W'(CPU_BASE));
   assign op       = port_op_e'(addr[1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
         tgt_q  <= '0;
      end else if (glob_sel) begin
         case (op)
            OP_SET: mask_q <= mask_q | wdata;
            OP_CLR: mask_q <= mask_q & ~wdata;
            OP_AUX: if (wdata < WORD_W'(NCPU)) tgt_q <= wdata[CPU_W-1:0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/irq_cpu_port.sv
module irq_cpu_port
   import irq_mask_pkg::*;
(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    set_en,
   input  logic                    clr_en,
   input  logic [WORD_W-1:SOFT_LSB+1] wbits,
   input  lvl_vec_t                eff_lv,
   input  lvl_vec_t                raw_lv,
   output logic [NLVL-1:1]         soft_q,
   output word_t                   pend_rd,
   output logic [LVL_W-1:0]        lvl_q
);
   lvl_vec_t all_lv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      soft_q <= '0;
      else if (set_en) soft_q <= soft_q | wbits;
      else if (clr_en) soft_q <= soft_q & ~wbits;
   end

   assign all_lv  = {soft_q, 1'b0} | eff_lv;
   assign pend_rd = {soft_q, 1'b0, raw_lv[NLVL-1:1], 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= top_level(all_lv);
   end
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
   import irq_mask_pkg::*;
#(
   parameter int NCPU = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [4:0]            addr,
   input  logic [31:0]           wdata,
   output logic [31:0]           rdata,
   input  logic [31:0]           dev_irq,
   input  logic [NCPU-1:0]       tick_irq,
   output logic [4*NCPU-1:0]     cpu_lvl
);
   localparam int CPU_W  = (NCPU > 1) ? $clog2(NCPU) : 1;
   localparam int SOFT_W = NLVL - 1;

   if (NCPU < 1 || NCPU > 4) begin : g_bad_ncpu
      $error("irq_mask_ctrl: NCPU must lie in 1..4");
   end

   word_t                 mask_q;
   logic [CPU_W-1:0]      tgt_q;
   word_t                 dev_eff;
   lvl_vec_t              lv_eff, lv_raw;
   logic                  tick_en;
   logic [NCPU*SOFT_W-1:0] soft_flat;
   word_t                 pend_rd [NCPU];
   port_op_e              op;

   assign op = port_op_e'(addr[1:0]);

   irq_global_regs #(.NCPU(NCPU), .CPU_W(CPU_W)) u_glob (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .mask_q(mask_q), .tgt_q(tgt_q)
   );

   assign dev_eff = dev_irq & ~mask_q & {WORD_W{~mask_q[MASK_ALL_BIT]}};
   assign tick_en = ~mask_q[TICK_GATE] & ~mask_q[MASK_ALL_BIT];

   irq_level_map u_map_eff (.src(dev_eff), .lv(lv_eff));
   irq_level_map u_map_raw (.src(dev_irq), .lv(lv_raw));

   for (genvar c = 0; c < NCPU; c++) begin : g_cpu
      localparam logic [ADDR_W-1:0] BASE = ADDR_W'(CPU_BASE + 4*c);
      logic     is_tgt, sel;
      lvl_vec_t tick_lv, eff_c, raw_c;
      logic [SOFT_W-1:0] soft_c;
      logic [LVL_W-1:0]  lvl_c;

      assign is_tgt  = (tgt_q == CPU_W'(c));
      assign sel     = wr_en && (addr[ADDR_W-1:2] == BASE[ADDR_W-1:2]);
      assign tick_lv = lvl_vec_t'(tick_irq[c]) << TICK_LVL;
      assign eff_c   = (is_tgt ? lv_eff : '0) | (tick_en ? tick_lv : '0);
      assign raw_c   = (is_tgt ? lv_raw : '0) | tick_lv;

      irq_cpu_port u_port (
         .clk(clk), .rst_n(rst_n),
         .set_en(sel && op == OP_SET), .clr_en(sel && op == OP_CLR),
         .wbits(wdata[WORD_W-1:SOFT_LSB+1]),
         .eff_lv(eff_c), .raw_lv(raw_c),
         .soft_q(soft_c), .pend_rd(pend_rd[c]), .lvl_q(lvl_c)
      );

      assign soft_flat[c*SOFT_W +: SOFT_W] = soft_c;
      assign cpu_lvl[c*LVL_W +: LVL_W]     = lvl_c;
   end

   always_comb begin
      rdata = '0;
      if (addr < ADDR_W'(CPU_BASE)) begin
         if (op == OP_READ)     rdata = mask_q;
         else if (op == OP_AUX) rdata = WORD_W'(tgt_q);
      end else if (op == OP_READ) begin
         for (int c = 0; c < NCPU; c++)
            if (addr[3:2] == 2'(c)) rdata = pend_rd[c];
      end
   end
endmodule

// File: rtl/irq_mask_ctrl_chk.sv
module irq_mask_ctrl_chk #(
   parameter int NCPU  = 4,
   parameter int CPU_W = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  wr_en,
   input logic [4:0]            addr,
   input logic [31:0]           wdata,
   input logic [31:0]           mask_q,
   input logic [CPU_W-1:0]      tgt_q,
   input logic [NCPU*15-1:0]    soft_flat,
   input logic [4*NCPU-1:0]     cpu_lvl
);
   // R1: reset forces mask and level outputs
   assert_reset_state_R1: assert property (@(posedge clk)
      !rst_n |=> (cpu_lvl == '0) && (mask_q == '1));

   // R2: set port raises the written ones
   assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 5'd1) |=> ((mask_q & $past(wdata)) == $past(wdata)));

   // R3: clear port drops the written ones
   assert_mask_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 5'd2) |=> ((mask_q & $past(wdata)) == '0));

   // R8: out-of-range steering write is ignored
   assert_tgt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 5'd3 && wdata >= 32'(NCPU)) |=> $stable(tgt_q));

   for (genvar c = 0; c < NCPU; c++) begin : g_c
      // R4: mask-all with no software level yields level 0
      assert_mask_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (mask_q[31] && soft_flat[c*15 +: 15] == '0) |=> (cpu_lvl[4*c +: 4] == 4'd0));

      // R9: per-processor set and clear of software levels
      assert_soft_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && addr == 5'(16 + 4*c + 1)) |=>
            ((soft_flat[c*15 +: 15] & $past(wdata[31:17])) == $past(wdata[31:17])));
      assert_soft_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && addr == 5'(16 + 4*c + 2)) |=>
            ((soft_flat[c*15 +: 15] & $past(wdata[31:17])) == '0));
   end
endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(.NCPU(NCPU), .CPU_W(CPU_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .mask_q(mask_q), .tgt_q(tgt_q), .soft_flat(soft_flat), .cpu_lvl(cpu_lvl)
);

// File: tb/tb_irq_mask_ctrl.sv
module tb_irq_mask_ctrl;
   localparam int NCPU = 4;
   localparam int NVEC = 17;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             wr_en;
   logic [4:0]       addr;
   logic [31:0]      wdata;
   logic [31:0]      rdata;
   logic [31:0]      dev_irq;
   logic [NCPU-1:0]  tick_irq;
   logic [4*NCPU-1:0] cpu_lvl;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   irq_mask_ctrl #(.NCPU(NCPU)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .dev_irq(dev_irq), .tick_irq(tick_irq), .cpu_lvl(cpu_lvl)
   );

   // {source pattern, expected level on the steered processor}  (R5, R6)
   localparam logic [35:0] VEC [NVEC] = '{
      {32'h0000_0001, 4'd2},  {32'h0000_0080, 4'd2},  {32'h0000_0002, 4'd3},
      {32'h0004_0000, 4'd4},  {32'h0000_0004, 4'd5},  {32'h0001_0000, 4'd6},
      {32'h0000_0008, 4'd7},  {32'h0010_0000, 4'd8},  {32'h4000_0000, 4'd9},
      {32'h0008_0000, 4'd10}, {32'h0040_0000, 4'd11}, {32'h0000_4000, 4'd12},
      {32'h0002_0000, 4'd13}, {32'h0000_2000, 4'd0},  {32'h3020_0040, 4'd0},
      {32'h0014_0000, 4'd8},  {32'h0002_0001, 4'd13}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      addr = a;
      #1 d = rdata;
   endtask

   function automatic logic [31:0] lvl(input int c);
      return 32'(cpu_lvl[4*c +: 4]);
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
      dev_irq = '0; tick_irq = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(5'd0, r);  check("R1 mask", r, 32'hFFFF_FFFF);
      rd(5'd3, r);  check("R1 target", r, 32'd0);
      rd(5'd16, r); check("R1 pend0", r, 32'd0);
      check("R1 levels", 32'(cpu_lvl), 32'd0);

      // R2/R3 mask ports
      wr(5'd2, 32'hFFFF_FFFF); rd(5'd0, r); check("R3 clear all", r, 32'h0);
      wr(5'd1, 32'h0000_0F0F); rd(5'd0, r); check("R2 set", r, 32'h0000_0F0F);
      wr(5'd1, 32'h0);         rd(5'd0, r); check("R2 zero write", r, 32'h0000_0F0F);
      wr(5'd2, 32'h0000_0003); rd(5'd0, r); check("R3 partial", r, 32'h0000_0F0C);
      rd(5'd1, r); check("R3 set port reads 0", r, 32'h0);
      wr(5'd2, 32'hFFFF_FFFF);

      // R5 mapping table walked, processor 0 is target
      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk); dev_irq = VEC[i][35:4];
         @(negedge clk);
         check($sformatf("R5 vec%0d", i), lvl(0), 32'(VEC[i][3:0]));
         check($sformatf("R7 vec%0d non-target", i), lvl(1), 32'd0);
      end
      @(negedge clk); dev_irq = 32'h0008_0000;   // level 10
      @(negedge clk);
      check("R5 timer source", lvl(0), 32'd10);

      // R4 mask-all
      wr(5'd1, 32'h8000_0000); @(negedge clk);
      check("R4 mask-all blocks", lvl(0), 32'd0);
      wr(5'd17, 32'h1 << 21); @(negedge clk);
      check("R4 soft passes", lvl(0), 32'd5);
      wr(5'd2, 32'h8000_0000); @(negedge clk);
      check("R11 highest wins", lvl(0), 32'd10);
      wr(5'd1, 32'h0008_0000); @(negedge clk);
      check("R5 own mask bit", lvl(0), 32'd5);
      wr(5'd2, 32'h0008_0000);
      wr(5'd18, 32'hFFFF_FFFF); @(negedge clk);
      check("R9 soft cleared", lvl(0), 32'd10);

      // R7 steering
      wr(5'd3, 32'd2); @(negedge clk);
      check("R7 old target", lvl(0), 32'd0);
      check("R7 new target", lvl(2), 32'd10);
      rd(5'd3, r); check("R7 target read", r, 32'd2);

      // R8 invalid steering writes
      wr(5'd3, 32'd7); rd(5'd3, r); check("R8 index 7", r, 32'd2);
      wr(5'd3, 32'd4); rd(5'd3, r); check("R8 index 4", r, 32'd2);
      @(negedge clk);
      check("R8 level stays", lvl(2), 32'd10);
      check("R8 cpu3 idle", lvl(3), 32'd0);

      // R6 tick lines
      @(negedge clk); tick_irq = 4'b0010;
      @(negedge clk); check("R6 tick", lvl(1), 32'd14);
      wr(5'd1, 32'h0000_0080); @(negedge clk);
      check("R6 tick gated", lvl(1), 32'd0);
      wr(5'd2, 32'h0000_0080); @(negedge clk);
      check("R6 tick ungated", lvl(1), 32'd14);
      @(negedge clk); tick_irq = '0;
      @(negedge clk); check("R6 tick dropped", lvl(1), 32'd0);

      // R9/R10 software levels on processor 2
      wr(5'd25, 32'hFFFF_FFFF); @(negedge clk);
      check("R9 level 15", lvl(2), 32'd15);
      check("R9 cpu3 untouched", lvl(3), 32'd0);
      check("R9 cpu0 untouched", lvl(0), 32'd0);
      rd(5'd24, r); check("R10 pend read", r, 32'hFFFE_0400);
      wr(5'd26, 32'h8000_0000); @(negedge clk);
      check("R9 clear top", lvl(2), 32'd14);
      wr(5'd26, 32'h0001_FFFF); @(negedge clk);
      check("R9 low bits ignored", lvl(2), 32'd14);
      rd(5'd24, r); check("R9 pend after", r, 32'h7FFE_0400);
      wr(5'd26, 32'hFFFF_FFFF); @(negedge clk);
      check("R9 cleared all", lvl(2), 32'd10);

      // R10 raw requests ignore the mask
      wr(5'd1, 32'hFFFF_FFFF);
      @(negedge clk); dev_irq = 32'h0004_0000;
      @(negedge clk);
      rd(5'd24, r); check("R10 raw on target", r, 32'h0000_0010);
      rd(5'd16, r); check("R10 raw non-target", r, 32'h0);
      check("R4 masked level", lvl(2), 32'd0);
      rd(5'd27, r); check("R10 offset 3", r, 32'h0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule